// File: doc/BRIEF.md
# Serial-Bus Core Control and Status Register File

This block holds the small set of quadlet-wide core registers that every node on a serial bus exposes to remote requesters. A transaction layer presents one request at a time. The request carries a byte offset inside the core register space, a byte length, a read/write flag and, for writes, one data quadlet. One clock later the block returns the read data and a response code.

The registers in the block are:
- the node identifier, whose bus-number field is writable;
- the split-transaction timeout, held as a seconds part and a fraction part. The block turns it into a clock-tick count for the local transaction timer.
- the cycle timer, sampled from the link;
- a bus-time register, whose seconds count advances each time the cycle timer wraps;
- the broadcast-channel register, in which only the valid bit can be written.

Misaligned requests are refused with a type error. Reserved and unimplemented offsets are refused with an address error.

A bus-reset pulse reloads the node identifier from the physical layer and restores the broadcast-channel register. The timeout, cycle and bus-time state are kept.

Top module: `csr_core_regs`

## Requirements
- R1: A request whose offset or byte length has either of its two low bits set returns response code 6 (type error) and read data 0, and changes no register.
- R2: Response codes are complete = 0, type error = 6 and address error = 7. The decoded quadlet offsets are:
  - node ID at 0x008;
  - reset-start at 0x00C;
  - split-timeout seconds at 0x018;
  - split-timeout fraction at 0x01C;
  - cycle time at 0x200;
  - bus time at 0x204;
  - busy-timeout at 0x210;
  - broadcast channel at 0x234.
  A read of reset-start returns a type error, and a write to it completes with no effect. Busy-timeout and every other offset return an address error. Any non-complete response carries read data 0.
- R3: After `rst` the registers read as follows: node ID 0, split seconds 0, split fraction 0x19000000 (800 in bits 31:19), cycle time 0, bus time 0, broadcast channel 0x8000001F.
- R4: A write to split-timeout seconds keeps only bits 2:0. A write to the fraction keeps only bits 31:19. All other bits read back as zero.
- R5: `timeout_ticks` equals (((seconds << 13) + fraction[31:19]) × TICK_HZ >> 13) + 1. It reflects a write one clock after that write's response appears.
- R6: Each cycle-time sample replaces the stored cycle time. When the sample is smaller than the stored value, bus time increases by 128, modulo 2^32.
- R7: A bus-time read returns the stored bits 31:7 ORed with the stored cycle time shifted right by 25. A bus-time write keeps only bits 31:7.
- R8: A node-ID write replaces only bits 31:22, which form the bus number. Bits 21:16, the physical node number, are kept, and bits 15:0 read as zero.
- R9: In the broadcast-channel register only bit 30 is writable. Bit 31 stays 1 and bits 29:0 stay 0x1F.
- R10: A `bus_reset` pulse sets the node ID to `phy_node_id` in bits 31:16 and returns the broadcast channel to 0x8000001F. Bus reset has priority over a write in the same cycle. It leaves the split timeout, cycle time and bus time unchanged.
- R11: `rsp_valid` is high exactly one clock after each accepted request and low otherwise. A quadlet-multiple length larger than 4 is served as a single quadlet.
- R12: A write to cycle time stores the full 32-bit value. A write takes priority over a sample in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus-reset pulse |
| phy_node_id | input | 16 | Node ID assigned by the physical layer |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in core register space |
| req_len | input | LEN_W | Request length in bytes |
| req_wdata | input | 32 | Write quadlet |
| cyc_smp_valid | input | 1 | Cycle-timer sample strobe |
| cyc_smp_value | input | 32 | Cycle-timer sample |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 4 | Response code |
| rsp_rdata | output | 32 | Read quadlet |
| timeout_ticks | output | TICK_W | Split timeout in clock ticks |

## Verification
A wrong mask or stale field in a register shows up on the first read of that offset. The error lies in `rsp_rdata` in the cycle after the request, so every write is followed by a read-back. A wrong tick computation appears on `timeout_ticks` one clock after the fraction or seconds write. The bench therefore sweeps all seconds values against several fractions, including the largest. A missed or doubled cycle-timer wrap stays hidden until bus time is read. The bench reads it after each sample, and it also checks that the seconds count rolls over from the top of its range.

// File: rtl/csr_regs_pkg.sv
package csr_regs_pkg;
  typedef enum logic [3:0] {
    RSP_OK       = 4'd0,
    RSP_TYPE_ERR = 4'd6,
    RSP_ADDR_ERR = 4'd7
  } rsp_code_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_NODE, SEL_RST_START, SEL_SPLIT_HI, SEL_SPLIT_LO,
    SEL_CYCLE, SEL_BUSTIME, SEL_BUSY, SEL_BCAST
  } reg_sel_e;

  localparam int unsigned OFF_NODE      = 'h008;
  localparam int unsigned OFF_RST_START = 'h00C;
  localparam int unsigned OFF_SPLIT_HI  = 'h018;
  localparam int unsigned OFF_SPLIT_LO  = 'h01C;
  localparam int unsigned OFF_CYCLE     = 'h200;
  localparam int unsigned OFF_BUSTIME   = 'h204;
  localparam int unsigned OFF_BUSY      = 'h210;
  localparam int unsigned OFF_BCAST     = 'h234;

  localparam int SEC_W      = 3;
  localparam int FRAC_W     = 13;
  localparam int FRAC_LSB   = 32 - FRAC_W;
  localparam int UNIT_W     = SEC_W + FRAC_W;
  localparam int FRAC_RESET = 800;
  localparam int BT_LSB     = 7;
  localparam int CYC_SHIFT  = 25;
  localparam int BUSNUM_W   = 10;
  localparam int PHYNUM_W   = 6;
  localparam int NODE_W     = BUSNUM_W + PHYNUM_W;
  localparam logic [29:0] BCAST_CHAN = 30'h1F;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              is_write,
  output reg_sel_e          sel,
  output rsp_code_e         code
);
  logic misaligned;
  assign misaligned = (addr[1:0] != 2'b00) || (len[1:0] != 2'b00);

  always_comb begin
    case (32'(addr))
      OFF_NODE:      sel = SEL_NODE;
      OFF_RST_START: sel = SEL_RST_START;
      OFF_SPLIT_HI:  sel = SEL_SPLIT_HI;
      OFF_SPLIT_LO:  sel = SEL_SPLIT_LO;
      OFF_CYCLE:     sel = SEL_CYCLE;
      OFF_BUSTIME:   sel = SEL_BUSTIME;
      OFF_BUSY:      sel = SEL_BUSY;
      OFF_BCAST:     sel = SEL_BCAST;
      default:       sel = SEL_NONE;
    endcase
  end

  always_comb begin
    if (misaligned)                             code = RSP_TYPE_ERR;
    else if (sel == SEL_NONE || sel == SEL_BUSY) code = RSP_ADDR_ERR;
    else if (sel == SEL_RST_START && !is_write)  code = RSP_TYPE_ERR;
    else                                         code = RSP_OK;
  end
endmodule

// File: rtl/csr_split_timeout.sv
module csr_split_timeout
  import csr_regs_pkg::*;
#(
  parameter int TICK_HZ = 1000,
  localparam int HZ_W   = $clog2(TICK_HZ + 1),
  localparam int PROD_W = UNIT_W + HZ_W,
  localparam int TICK_W = PROD_W - FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sec,
  input  logic              wr_frac,
  input  logic [31:0]       wdata,
  output logic [SEC_W-1:0]  sec_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic [TICK_W-1:0] ticks_q
);
  localparam int RST_TICKS_I = ((FRAC_RESET * TICK_HZ) >> FRAC_W) + 1;
  localparam logic [TICK_W-1:0] RST_TICKS = TICK_W'(RST_TICKS_I);

  logic [UNIT_W-1:0] units;
  logic [PROD_W-1:0] prod;
  assign units = {sec_q, frac_q};
  assign prod  = PROD_W'(units) * PROD_W'(TICK_HZ);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q   <= '0;
      frac_q  <= FRAC_W'(FRAC_RESET);
      ticks_q <= RST_TICKS;
    end else begin
      if (wr_sec)  sec_q  <= wdata[SEC_W-1:0];
      if (wr_frac) frac_q <= wdata[31:FRAC_LSB];
      ticks_q <= TICK_W'(prod >> FRAC_W) + TICK_W'(1);
    end
  end

  // R5
  ticks_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ticks_q != '0);
  // R5
  ticks_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_sec && !wr_frac && !$past(wr_sec) && !$past(wr_frac) && !$past(rst))
      |=> $stable(ticks_q));
endmodule

// File: rtl/csr_bus_clock.sv
module csr_bus_clock
  import csr_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [31:0]       smp_value,
  input  logic              wr_cycle,
  input  logic              wr_bus,
  input  logic [31:0]       wdata,
  output logic [31:0]       cycle_q,
  output logic [31-BT_LSB:0] bus_q
);
  logic wrapped;
  assign wrapped = smp_valid && (smp_value < cycle_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_q <= '0;
      bus_q   <= '0;
    end else begin
      if (wr_cycle)       cycle_q <= wdata;
      else if (smp_valid) cycle_q <= smp_value;
      if (wr_bus)         bus_q <= wdata[31:BT_LSB];
      else if (wrapped)   bus_q <= bus_q + 1'b1;
    end
  end

  // R6
  bus_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !wr_cycle && !wr_bus && smp_value < cycle_q)
      |=> bus_q == $past(bus_q) + 1'b1);
  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !wr_bus) |=> $stable(bus_q));
endmodule

// File: rtl/csr_core_regs.sv
module csr_core_regs
  import csr_regs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int LEN_W   = 10,
  parameter int TICK_HZ = 1000,
  localparam int TICK_W = UNIT_W + $clog2(TICK_HZ + 1) - FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic [15:0]       phy_node_id,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  input  logic              cyc_smp_valid,
  input  logic [31:0]       cyc_smp_value,
  output logic              rsp_valid,
  output logic [3:0]        rsp_code,
  output logic [31:0]       rsp_rdata,
  output logic [TICK_W-1:0] timeout_ticks
);
  reg_sel_e  sel;
  rsp_code_e code;
  logic      ok, wr;

  csr_addr_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
    .addr(req_addr), .len(req_len), .is_write(req_write),
    .sel(sel), .code(code));

  assign ok = req_valid && (code == RSP_OK);
  assign wr = ok && req_write;

  logic [SEC_W-1:0]  sec_q;
  logic [FRAC_W-1:0] frac_q;

  csr_split_timeout #(.TICK_HZ(TICK_HZ)) u_to (
    .clk(clk), .rst(rst),
    .wr_sec(wr && sel == SEL_SPLIT_HI), .wr_frac(wr && sel == SEL_SPLIT_LO),
    .wdata(req_wdata), .sec_q(sec_q), .frac_q(frac_q), .ticks_q(timeout_ticks));

  logic [31:0]        cycle_q;
  logic [31-BT_LSB:0] bus_q;

  csr_bus_clock u_clk (
    .clk(clk), .rst(rst), .smp_valid(cyc_smp_valid), .smp_value(cyc_smp_value),
    .wr_cycle(wr && sel == SEL_CYCLE), .wr_bus(wr && sel == SEL_BUSTIME),
    .wdata(req_wdata), .cycle_q(cycle_q), .bus_q(bus_q));

  logic [NODE_W-1:0] node_q;
  logic              bvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      node_q   <= '0;
      bvalid_q <= 1'b0;
    end else if (bus_reset) begin
      node_q   <= phy_node_id;
      bvalid_q <= 1'b0;
    end else begin
      if (wr && sel == SEL_NODE)
        node_q[NODE_W-1:PHYNUM_W] <= req_wdata[31:32-BUSNUM_W];
      if (wr && sel == SEL_BCAST)
        bvalid_q <= req_wdata[30];
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (sel)
      SEL_NODE:     rd_mux = {node_q, 16'h0};
      SEL_SPLIT_HI: rd_mux = {{(32-SEC_W){1'b0}}, sec_q};
      SEL_SPLIT_LO: rd_mux = {frac_q, {FRAC_LSB{1'b0}}};
      SEL_CYCLE:    rd_mux = cycle_q;
      SEL_BUSTIME:  rd_mux = {bus_q, {BT_LSB{1'b0}}} | (cycle_q >> CYC_SHIFT);
      SEL_BCAST:    rd_mux = {1'b1, bvalid_q, BCAST_CHAN};
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code  <= code;
        rsp_rdata <= (ok && !req_write) ? rd_mux : 32'h0;
      end
    end
  end

  // R1
  misalign_type_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_addr[1:0] != 0 || req_len[1:0] != 0))
      |=> rsp_valid && rsp_code == 4'd6 && rsp_rdata == 32'h0);
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R8
  phys_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_reset |=> node_q[PHYNUM_W-1:0] == $past(node_q[PHYNUM_W-1:0]));
  // R9
  bcast_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_BCAST && !bus_reset) |=> bvalid_q == $past(req_wdata[30]));
  // R10
  bus_reset_chk: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> node_q == $past(phy_node_id) && !bvalid_q);
endmodule

// File: tb/csr_core_regs_tb.sv
module csr_core_regs_tb_top;
  localparam int TICK_HZ = 1000;
  localparam int TICK_W  = 14;

  logic clk = 0, rst = 1, bus_reset = 0;
  logic [15:0] phy_node_id = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [9:0]  req_len = 0;
  logic [31:0] req_wdata = 0;
  logic cyc_smp_valid = 0;
  logic [31:0] cyc_smp_value = 0;
  logic rsp_valid;
  logic [3:0] rsp_code;
  logic [31:0] rsp_rdata;
  logic [TICK_W-1:0] timeout_ticks;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  csr_core_regs #(.ADDR_W(12), .LEN_W(10), .TICK_HZ(TICK_HZ)) dut_i (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .phy_node_id(phy_node_id),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .cyc_smp_valid(cyc_smp_valid),
    .cyc_smp_value(cyc_smp_value), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_rdata(rsp_rdata), .timeout_ticks(timeout_ticks));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [3:0]  r_code;
  logic [31:0] r_data;
  logic        r_valid;

  task automatic access(bit w, logic [11:0] a, logic [9:0] l, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_len = l; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    r_valid = rsp_valid; r_code = rsp_code; r_data = rsp_rdata;
  endtask

  task automatic rd(logic [11:0] a); access(0, a, 10'd4, 32'h0); endtask
  task automatic wrq(logic [11:0] a, logic [31:0] d); access(1, a, 10'd4, d); endtask

  task automatic sample(logic [31:0] v);
    @(negedge clk);
    cyc_smp_valid = 1; cyc_smp_value = v;
    @(posedge clk);
    @(negedge clk);
    cyc_smp_valid = 0;
  endtask

  function automatic logic [3:0] exp_code(logic [11:0] a, bit w);
    case (a)
      12'h008, 12'h018, 12'h01C, 12'h200, 12'h204, 12'h234: return 4'd0;
      12'h00C: return w ? 4'd0 : 4'd6;
      default: return 4'd7;
    endcase
  endfunction

  function automatic logic [31:0] reset_val(logic [11:0] a);
    case (a)
      12'h01C: return 32'h1900_0000;
      12'h234: return 32'h8000_001F;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_ticks(int s, int f);
    return (((s * 8192 + f) * TICK_HZ) >> 13) + 1;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int fr[4];
    fr[0] = 0; fr[1] = 1; fr[2] = 800; fr[3] = 8191;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R3 reset state, R11 no response when idle
    chk("R11 idle rsp_valid", 32'(rsp_valid), 0);
    chk("R3 reset ticks", 32'(timeout_ticks), exp_ticks(0, 800));

    // R2/R3 exhaustive sweep over every quadlet offset
    for (int q = 0; q < 1024; q++) begin
      logic [11:0] a;
      a = 12'(q * 4);
      rd(a);
      chk("R11 rsp_valid", 32'(r_valid), 1);
      chk("R2 read code", 32'(r_code), 32'(exp_code(a, 0)));
      chk("R3 reset read", r_data, (exp_code(a, 0) == 0) ? reset_val(a) : 32'h0);
    end

    // R2 writes to busy-timeout and unlisted offsets, reset-start write
    wrq(12'h210, 32'hFFFF_FFFF); chk("R2 busy write code", 32'(r_code), 7);
    wrq(12'h100, 32'hFFFF_FFFF); chk("R2 gap write code", 32'(r_code), 7);
    wrq(12'h00C, 32'hFFFF_FFFF); chk("R2 reset-start write code", 32'(r_code), 0);

    // R1 misalignment sweep on node-ID writes
    for (int al = 0; al < 4; al++)
      for (int ll = 0; ll < 4; ll++)
        if (al != 0 || ll != 0) begin
          access(1, 12'(12'h008 + al), 10'(8 + ll), 32'hFFFF_FFFF);
          chk("R1 misaligned code", 32'(r_code), 6);
          chk("R1 misaligned data", r_data, 0);
        end
    rd(12'h008); chk("R1 node unchanged", r_data, 32'h0);

    // R11 long quadlet-multiple length
    access(0, 12'h234, 10'd16, 0);
    chk("R11 long length code", 32'(r_code), 0);
    chk("R11 long length data", r_data, 32'h8000_001F);

    // R4/R5 sweep of seconds against fractions
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++) begin
        wrq(12'h018, 32'hFFFF_FFF8 | 32'(s));
        wrq(12'h01C, (32'(fr[k]) << 19) | 32'h0007_FFFF);
        @(posedge clk); @(negedge clk);
        chk("R5 ticks", 32'(timeout_ticks), exp_ticks(s, fr[k]));
        rd(12'h018); chk("R4 seconds mask", r_data, 32'(s));
        rd(12'h01C); chk("R4 fraction mask", r_data, 32'(fr[k]) << 19);
      end

    // R6/R7/R12 cycle timer and bus time
    sample(32'h0000_1000);
    rd(12'h200); chk("R6 cycle stored", r_data, 32'h0000_1000);
    rd(12'h204); chk("R6 no wrap", r_data, 32'h0);
    sample(32'hFE00_0000);
    rd(12'h204); chk("R7 low bits from cycle", r_data, 32'h7F);
    sample(32'h0000_0010);
    rd(12'h204); chk("R6 wrap adds 128", r_data, 32'h80);
    sample(32'h0600_0000);
    rd(12'h204); chk("R7 or of cycle bits", r_data, 32'h83);
    wrq(12'h204, 32'hFFFF_FFFF);
    rd(12'h204); chk("R7 write mask", r_data, 32'hFFFF_FF83);
    sample(32'h0);
    rd(12'h204); chk("R6 seconds rollover", r_data, 32'h0);
    wrq(12'h200, 32'h1234_5678);
    rd(12'h200); chk("R12 cycle write", r_data, 32'h1234_5678);
    sample(32'h1234_5677);
    rd(12'h204); chk("R6 wrap after write", r_data, 32'h89);

    // R8 node-ID write
    @(negedge clk); phy_node_id = 16'h0025; bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    rd(12'h008); chk("R10 node from phy", r_data, 32'h0025_0000);
    wrq(12'h008, 32'hFFFF_FFFF);
    rd(12'h008); chk("R8 bus number only", r_data, 32'hFFE5_0000);
    wrq(12'h008, 32'h0000_0000);
    rd(12'h008); chk("R8 clear bus number", r_data, 32'h0025_0000);

    // R9 broadcast channel
    wrq(12'h234, 32'h0000_0000);
    rd(12'h234); chk("R9 fixed bits kept", r_data, 32'h8000_001F);
    wrq(12'h234, 32'hFFFF_FFFF);
    rd(12'h234); chk("R9 valid set", r_data, 32'hC000_001F);

    // R10 bus reset beats a same-cycle write, keeps timing state
    @(negedge clk);
    phy_node_id = 16'h3FC1; bus_reset = 1;
    req_valid = 1; req_write = 1; req_addr = 12'h008; req_len = 4; req_wdata = 32'h0;
    @(negedge clk); bus_reset = 0; req_valid = 0;
    rd(12'h008); chk("R10 node priority", r_data, 32'h3FC1_0000);
    rd(12'h234); chk("R10 bcast restored", r_data, 32'h8000_001F);
    rd(12'h01C); chk("R10 fraction kept", r_data, 32'(8191) << 19);
    rd(12'h200); chk("R10 cycle kept", r_data, 32'h1234_5677);
    chk("R10 ticks kept", 32'(timeout_ticks), exp_ticks(7, 8191));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule